// File: doc/BRIEF.md
# Up/Down Wiper Position Controller

This block is the digital control section of a 100-position trim potentiometer. A host drives three slow, asynchronous pins: an active-low select, a step strobe and a direction bit. While selected, every high-to-low transition of the strobe moves the wiper one position up or down. The position saturates at both ends and never wraps. The block drives a one-hot tap-select vector that an analog switch array consumes. It also presents the position in binary.

A retained register models the nonvolatile copy of the position. Releasing the select while the strobe is high commits the live position to that register. A timed store then runs and reports busy, and the block drops into standby when it ends. Releasing the select while the strobe is low keeps the new position live without a store. The reset input stands in for power-up: it reloads the live position from the retained copy. Before the first store, that copy holds a parameter value (mid-scale by default).

The controller is a three-state machine. STANDBY is deselected and idle. SELECTED accepts steps. STORING runs the timed write. The transitions are:
- STANDBY→SELECTED when the synchronized select is low.
- SELECTED→STORING on deselect with the strobe high.
- SELECTED→STANDBY on deselect with the strobe low.
- STORING→STANDBY when the store timer expires.

Top module: `trim_wiper_ctrl`

## Requirements
- R1: After reset, `pos_o` equals the retained value, `busy_o` is 0 and `standby_o` is 1. Before any store, the retained value is `RESET_POS` (default 49).
- R2: While selected (`sel_n_i` low), each falling edge of `step_i` moves `pos_o` by one. The move is upward when `dir_i` is 1 and downward when `dir_i` is 0.
- R3: While `sel_n_i` is high, falling edges of `step_i` leave `pos_o` unchanged.
- R4: `pos_o` stays within 0..`NTAPS`-1 (0..99). A step up at 99 leaves 99, a step down at 0 leaves 0, and the position never wraps.
- R5: A rising edge of `sel_n_i` while `step_i` is high copies `pos_o` into the retained register. `busy_o` is then high for exactly `STORE_CYC` clock cycles, after which the block is in standby.
- R6: A rising edge of `sel_n_i` while `step_i` is low performs no store. `busy_o` stays 0, the block enters standby at once, the retained value is unchanged, and the live position is kept.
- R7: A reset after a store reloads `pos_o` with the most recently stored position.
- R8: While `busy_o` is high, strobe edges do not move the wiper and reselection is deferred. A select held low through the store takes effect only after `busy_o` falls.
- R9: `tap_sel_o` has exactly one bit set, at bit index `pos_o`.
- R10: `dir_i` may change between steps within one selection, and each step follows the direction level present at that step.
- R11: `standby_o` is 0 while the block is selected and not storing. It is 1 when the block is deselected and no store is running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset, models power-up recall |
| sel_n_i | input | 1 | Asynchronous active-low select |
| step_i | input | 1 | Asynchronous step strobe, acts on falling edge |
| dir_i | input | 1 | Asynchronous direction, 1 = up, 0 = down |
| tap_sel_o | output | NTAPS (100) | One-hot tap select |
| pos_o | output | $clog2(NTAPS) (7) | Binary wiper position |
| busy_o | output | 1 | Store cycle in progress |
| standby_o | output | 1 | Deselected and idle |

## Verification
Each pin passes through a two-flop synchronizer and then an edge register. A pin change made between clock edges therefore shows up on `pos_o`, `tap_sel_o`, `busy_o` or `standby_o` at the third rising edge after it. The bench drives pins on falling clock edges and holds each level for three or four cycles before sampling on a later falling edge, so every result has settled when it is checked. The store length is measured by sampling `busy_o` on every falling edge after deselect, which gives an exact cycle count to compare with `STORE_CYC`.

// File: rtl/trim_wiper_pkg.sv
`timescale 1ns/1ps
package trim_wiper_pkg;
    typedef enum logic [1:0] {
        ST_STANDBY  = 2'd0,
        ST_SELECTED = 2'd1,
        ST_STORING  = 2'd2
    } wiper_state_e;
endpackage

// File: rtl/trim_wiper_sync.sv
`timescale 1ns/1ps
module trim_wiper_sync #(
    parameter int WIDTH = 3,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic meta_q;
        logic stab_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= RST_VAL[i];
                stab_q <= RST_VAL[i];
            end else begin
                meta_q <= d_i[i];
                stab_q <= meta_q;
            end
        end
        assign q_o[i] = stab_q;
    end
endmodule

// File: rtl/trim_wiper_position.sv
`timescale 1ns/1ps
module trim_wiper_position #(
    parameter int NTAPS     = 100,
    parameter int RESET_POS = 49,
    localparam int PW       = $clog2(NTAPS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          move_i,
    input  logic          up_i,
    input  logic          commit_i,
    output logic [PW-1:0] pos_o,
    output logic [PW-1:0] kept_o
);
    localparam logic [PW-1:0] MAXP = PW'(NTAPS - 1);

    logic [PW-1:0] pos_q;
    logic [PW-1:0] kept_q = PW'(RESET_POS);

    // Live position: reset recalls the retained copy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= kept_q;
        end else if (move_i) begin
            if (up_i && pos_q != MAXP) begin
                pos_q <= pos_q + PW'(1);
            end else if (!up_i && pos_q != '0) begin
                pos_q <= pos_q - PW'(1);
            end
        end
    end

    // Retained copy survives reset
    always_ff @(posedge clk) begin
        if (rst_n && commit_i) begin
            kept_q <= pos_q;
        end
    end

    assign pos_o  = pos_q;
    assign kept_o = kept_q;

    assert_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pos_q <= MAXP);
    assert_no_wrap_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_q == MAXP) |=> (pos_q != '0));
    assert_no_wrap_bottom_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_q == '0) |=> (pos_q != MAXP));
    assert_recall_R7: assert property (@(posedge clk)
        !rst_n |=> (pos_q == kept_q));
    assert_commit_copy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        commit_i |=> (kept_q == $past(pos_q)));
    assert_hold_when_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !move_i |=> $stable(pos_q));
endmodule

// File: rtl/trim_wiper_decode.sv
`timescale 1ns/1ps
module trim_wiper_decode #(
    parameter int NTAPS = 100,
    localparam int PW   = $clog2(NTAPS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PW-1:0]    pos_i,
    output logic [NTAPS-1:0] tap_o
);
    for (genvar t = 0; t < NTAPS; t++) begin : g_tap
        assign tap_o[t] = (pos_i == PW'(t));
    end

    assert_one_tap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(tap_o) == 1);
    assert_tap_index_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tap_o[pos_i]);
endmodule

// File: rtl/trim_wiper_ctrl.sv
`timescale 1ns/1ps
module trim_wiper_ctrl
    import trim_wiper_pkg::*;
#(
    parameter int NTAPS     = 100,
    parameter int RESET_POS = 49,
    parameter int STORE_CYC = 32,
    localparam int PW       = $clog2(NTAPS),
    localparam int TW       = $clog2(STORE_CYC + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_n_i,
    input  logic             step_i,
    input  logic             dir_i,
    output logic [NTAPS-1:0] tap_sel_o,
    output logic [PW-1:0]    pos_o,
    output logic             busy_o,
    output logic             standby_o
);
    logic [2:0]   sync_q;
    logic         sel_s, step_s, dir_s;
    logic         sel_q, step_q;
    logic         step_fall, deselect;
    logic         move_en, commit;
    logic [TW-1:0] tmr_q;
    logic         tmr_done;
    logic [PW-1:0] kept;
    wiper_state_e state_q, state_d;

    trim_wiper_sync #(.WIDTH(3), .RST_VAL(3'b110)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({sel_n_i, step_i, dir_i}),
        .q_o   (sync_q)
    );
    assign {sel_s, step_s, dir_s} = sync_q;

    // Previous-cycle levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= 1'b1;
            step_q <= 1'b1;
        end else begin
            sel_q  <= sel_s;
            step_q <= step_s;
        end
    end

    assign step_fall = step_q & ~step_s;
    assign deselect  = ~sel_q & sel_s;
    assign tmr_done  = (tmr_q == TW'(STORE_CYC - 1));

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STANDBY:  if (!sel_s) state_d = ST_SELECTED;
            ST_SELECTED: if (deselect) state_d = step_q ? ST_STORING : ST_STANDBY;
            ST_STORING:  if (tmr_done) state_d = ST_STANDBY;
            default:     state_d = ST_STANDBY;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_STANDBY;
        else        state_q <= state_d;
    end

    // Store timer
    always_ff @(posedge clk) begin
        if (!rst_n || state_q != ST_STORING) tmr_q <= '0;
        else                                 tmr_q <= tmr_q + TW'(1);
    end

    // Outputs and datapath controls
    always_comb begin
        busy_o    = (state_q == ST_STORING);
        standby_o = (state_q == ST_STANDBY);
        move_en   = (state_q != ST_STORING) && !sel_s && step_fall;
        commit    = (state_q == ST_SELECTED) && deselect && step_q;
    end

    trim_wiper_position #(.NTAPS(NTAPS), .RESET_POS(RESET_POS)) u_pos (
        .clk      (clk),
        .rst_n    (rst_n),
        .move_i   (move_en),
        .up_i     (dir_s),
        .commit_i (commit),
        .pos_o    (pos_o),
        .kept_o   (kept)
    );

    trim_wiper_decode #(.NTAPS(NTAPS)) u_dec (
        .clk   (clk),
        .rst_n (rst_n),
        .pos_i (pos_o),
        .tap_o (tap_sel_o)
    );

    assert_store_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable(pos_o));
    assert_store_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> (kept == pos_o));
    assert_timer_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (tmr_q < TW'(STORE_CYC)));
    assert_wake_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (standby_o && !sel_s) |=> !standby_o);
    assert_deselected_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sel_s |=> $stable(pos_o));
    assert_state_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({busy_o, standby_o}));
endmodule

// File: tb/trim_wiper_ctrl_bench.sv
`timescale 1ns/1ps
module trim_wiper_ctrl_bench;
    localparam int NTAPS     = 100;
    localparam int RESET_POS = 49;
    localparam int STORE_CYC = 32;
    localparam int PW        = $clog2(NTAPS);

    logic clk = 1'b0;
    logic rst_n, sel_n, step, dir;
    logic [NTAPS-1:0] tap_sel;
    logic [PW-1:0]    pos;
    logic             busy, standby;

    int checks = 0;
    int errors = 0;
    int exp_pos, exp_kept;
    bit selected;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    trim_wiper_ctrl #(.NTAPS(NTAPS), .RESET_POS(RESET_POS), .STORE_CYC(STORE_CYC)) u_trim_wiper_ctrl (
        .clk(clk), .rst_n(rst_n), .sel_n_i(sel_n), .step_i(step), .dir_i(dir),
        .tap_sel_o(tap_sel), .pos_o(pos), .busy_o(busy), .standby_o(standby)
    );

    function automatic int step_model(input int p, input bit up);
        if (up)  return (p < NTAPS - 1) ? p + 1 : p;
        else     return (p > 0) ? p - 1 : p;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_wiper(input string req);
        logic [NTAPS-1:0] exp_tap;
        exp_tap = '0;
        exp_tap[exp_pos] = 1'b1;
        chk(req, int'(pos), exp_pos);
        checks++;
        if (tap_sel !== exp_tap) begin
            errors++;
            $display("FAIL R9 (%s): actual %h expected %h", req, tap_sel, exp_tap);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_select();
        sel_n = 1'b0; wait_n(4); selected = 1'b1;
    endtask

    task automatic pulse(input bit up);
        dir = up; wait_n(1);
        step = 1'b0; wait_n(3);
        step = 1'b1; wait_n(3);
        if (selected) exp_pos = step_model(exp_pos, up);
    endtask

    task automatic desel_store(input string req);
        int busy_cnt = 0;
        sel_n = 1'b1; selected = 1'b0;
        for (int i = 0; i < STORE_CYC + 20; i++) begin
            @(negedge clk);
            if (busy) busy_cnt++;
        end
        exp_kept = exp_pos;
        chk({req, " busy length"}, busy_cnt, STORE_CYC);
        chk({req, " standby after store"}, int'(standby), 1);
    endtask

    task automatic desel_nostore(input bit up);
        int busy_seen = 0;
        dir = up; wait_n(1);
        step = 1'b0; wait_n(4);
        if (selected) exp_pos = step_model(exp_pos, up);
        sel_n = 1'b1; selected = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (busy) busy_seen++;
        end
        step = 1'b1; wait_n(4);
        chk("R6 no busy without store", busy_seen, 0);
        chk("R6 standby at once", int'(standby), 1);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; wait_n(2);
        rst_n = 1'b1; wait_n(4);
        exp_pos = exp_kept;
    endtask

    initial begin
        int r;
        r = $urandom(32'd20240611);
        rst_n = 1'b0; sel_n = 1'b1; step = 1'b1; dir = 1'b0;
        selected = 1'b0;
        exp_kept = RESET_POS; exp_pos = RESET_POS;
        wait_n(3); rst_n = 1'b1; wait_n(4);

        chk_wiper("R1 reset position");
        chk("R1 busy after reset", int'(busy), 0);
        chk("R1 standby after reset", int'(standby), 1);

        do_select();
        chk("R11 standby low when selected", int'(standby), 0);
        pulse(1'b1);
        chk_wiper("R2 step up");
        pulse(1'b0); pulse(1'b0);
        chk_wiper("R10 direction change within selection");

        for (int i = 0; i < 60; i++) pulse(1'b1);
        chk_wiper("R4 top saturation");
        chk("R4 stays at top", int'(pos), NTAPS - 1);
        for (int i = 0; i < 110; i++) pulse(1'b0);
        chk_wiper("R4 bottom saturation");
        chk("R4 stays at bottom", int'(pos), 0);

        for (int i = 0; i < 5; i++) pulse(1'b1);
        desel_store("R5");
        chk_wiper("R5 position after store");

        pulse(1'b1); pulse(1'b1); pulse(1'b1);
        chk_wiper("R3 steps ignored while deselected");

        do_select(); pulse(1'b1);
        desel_nostore(1'b1);
        chk_wiper("R6 live position kept");
        do_reset();
        chk_wiper("R7 recall of stored value after no-store");

        do_select();
        sel_n = 1'b1; selected = 1'b0;
        wait_n(4);
        chk("R5 busy during store", int'(busy), 1);
        sel_n = 1'b0;
        step = 1'b0; wait_n(3); step = 1'b1; wait_n(3);
        chk("R8 still busy", int'(busy), 1);
        chk_wiper("R8 step ignored while storing");
        while (busy) @(negedge clk);
        wait_n(4);
        selected = 1'b1;
        chk("R8 deferred reselect", int'(standby), 0);
        exp_kept = exp_pos;
        pulse(1'b0);
        chk_wiper("R2 step down after deferred reselect");
        desel_store("R5 second store");
        do_reset();
        chk_wiper("R7 recall of last store");

        for (int it = 0; it < 250; it++) begin
            int op;
            op = int'($urandom % 10);
            if (op == 9 && !selected) begin
                do_reset();
                chk_wiper("R7 random recall");
            end else begin
                if (!selected) do_select();
                if (op <= 6) begin
                    pulse(1'($urandom % 2));
                    chk_wiper("R2 random step");
                end else if (op == 7) begin
                    desel_store("R5 random");
                    chk_wiper("R5 random store");
                end else begin
                    desel_nostore(1'($urandom % 2));
                    chk_wiper("R6 random no-store");
                end
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule